// File: doc/BRIEF.md
# Fetch Link Peripheral Byte Buffers

This block holds the two byte queues on the peripheral side of a byte-wide fetch link. A requester writes command bytes into one queue and reads response bytes from the other. Downstream logic (a command parser and a memory reader, which are not part of this block) drains the command queue and fills the response queue through a simple push/pop side.

The requester may sample the two flow-control flags several cycles before it acts on them. For that reason the flags obey strict causality. The command-side full flag can only rise as a result of a requester write. The response-side empty flag can only rise as a result of a requester read. Activity on the internal side can only lower these flags.

A requester read issued while the response queue reports empty is taken as an in-band reset. That read empties the command queue, which throws away any partial command. It also produces a one-cycle reset pulse for downstream logic.

Top module: `fetch_link_buffers`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `req_tx_full` is 0, `req_rx_empty` is 1, `link_reset` is 0, `cmd_valid` is 0 and `rsp_space` is 1.
- R2: Accepted command bytes leave on `cmd_data` in the order written. `cmd_valid` is 1 exactly when the command queue holds at least one byte, and `cmd_data` shows the oldest byte. `cmd_pop` removes that byte at the clock edge.
- R3: `req_tx_full` goes high in the cycle after a requester write that brings the command queue to DEPTH bytes. It never rises unless `req_tx_wr` was high in the previous cycle.
- R4: An internal `cmd_pop` while the queue is full lowers `req_tx_full` in the next cycle. Without requester writes, `req_tx_full` stays low whatever the internal side does.
- R5: A requester write while the command queue holds DEPTH bytes is dropped and stores nothing. A write and a pop in the same cycle on a full queue remove one byte and add none.
- R6: Pushed response bytes appear on `req_rx_data` oldest first whenever `req_rx_empty` is 0. A `rsp_push` into an empty response queue lowers `req_rx_empty` in the next cycle.
- R7: `req_rx_empty` goes high in the cycle after a requester read that removes the last response byte. It never rises unless `req_rx_rd` was high in the previous cycle.
- R8: A requester read while `req_rx_empty` is 1 is a reset request. In the next cycle `link_reset` is 1 for exactly one cycle, the command queue is empty (`cmd_valid` 0, `req_tx_full` 0), and a requester write or `cmd_pop` in the same cycle has no effect.
- R9: `rsp_space` is 0 exactly when the response queue holds DEPTH bytes. A `rsp_push` at that point is dropped.
- R10: Both queues hold DEPTH bytes, where DEPTH is a parameter of at least 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_tx_data | input | 8 | Command byte from the requester |
| req_tx_wr | input | 1 | Requester write strobe for the command queue |
| req_tx_full | output | 1 | Command queue full (registered) |
| req_rx_data | output | 8 | Oldest response byte |
| req_rx_rd | input | 1 | Requester read strobe; when empty, a reset request |
| req_rx_empty | output | 1 | Response queue empty (registered) |
| cmd_pop | input | 1 | Internal pop of the command queue |
| cmd_data | output | 8 | Oldest command byte |
| cmd_valid | output | 1 | Command queue non-empty |
| rsp_push | input | 1 | Internal push into the response queue |
| rsp_data | input | 8 | Response byte to push |
| rsp_space | output | 1 | Response queue can accept a byte |
| link_reset | output | 1 | One-cycle pulse after an in-band reset request |

## Verification
The flag-causality properties assume only what the port rules allow. The requester may write while full or read while empty. The internal side may pop an empty command queue or push into a full response queue, and each of these is either ignored or decoded as a reset. The stimulus deliberately drives all of these cases, both in directed sequences and in a long random mix that includes simultaneous writes, pops, pushes and reads. Reset is asserted only at the start, so the reset-relative properties always see a history that begins at reset.

// File: rtl/fetch_buf_pkg.sv
package fetch_buf_pkg;
  typedef logic [7:0] byte_t;
  localparam int MIN_DEPTH = 8;

  function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo
  import fetch_buf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  byte_t         din,
  input  logic          pop,
  output byte_t         head,
  output logic [CW-1:0] count
);
  byte_t          mem [DEPTH];
  logic [AW-1:0]  wr_ptr, rd_ptr;
  logic           do_push, do_pop;

  assign do_push = push && !clr && (count != CW'(DEPTH));
  assign do_pop  = pop  && !clr && (count != '0);

  // storage: no reset, so it maps onto inferred RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  assign head = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= AW'(wrap_inc(int'(wr_ptr), DEPTH));
      if (do_pop)  rd_ptr <= AW'(wrap_inc(int'(rd_ptr), DEPTH));
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
endmodule

// File: rtl/link_reset_detect.sv
module link_reset_detect (
  input  logic clk,
  input  logic rst,
  input  logic rd,
  input  logic empty,
  output logic flush,
  output logic pulse
);
  assign flush = rd && empty;

  always_ff @(posedge clk) begin
    if (rst) pulse <= 1'b0;
    else     pulse <= flush;
  end

  // R8
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    pulse && !$past(flush, 1) |-> 1'b0);
endmodule

// File: rtl/fetch_link_buffers.sv
module fetch_link_buffers
  import fetch_buf_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] req_tx_data,
  input  logic       req_tx_wr,
  output logic       req_tx_full,
  output logic [7:0] req_rx_data,
  input  logic       req_rx_rd,
  output logic       req_rx_empty,
  input  logic       cmd_pop,
  output logic [7:0] cmd_data,
  output logic       cmd_valid,
  input  logic       rsp_push,
  input  logic [7:0] rsp_data,
  output logic       rsp_space,
  output logic       link_reset
);
  localparam int CW = $clog2(DEPTH + 1);

  // R10
  initial depth_min_chk: assert (DEPTH >= MIN_DEPTH);

  logic          flush;
  logic [CW-1:0] cmd_cnt, rsp_cnt, cmd_cnt_nxt, rsp_cnt_nxt;
  logic          cmd_push_ok, cmd_pop_ok, rsp_push_ok, rsp_pop_ok;
  logic          full_q, empty_q;

  link_reset_detect u_rstdet (
    .clk(clk), .rst(rst), .rd(req_rx_rd), .empty(empty_q),
    .flush(flush), .pulse(link_reset)
  );

  assign cmd_push_ok = req_tx_wr && (cmd_cnt != CW'(DEPTH)) && !flush;
  assign cmd_pop_ok  = cmd_pop && (cmd_cnt != '0) && !flush;
  assign cmd_cnt_nxt = flush ? '0 : cmd_cnt + CW'(cmd_push_ok) - CW'(cmd_pop_ok);

  assign rsp_push_ok = rsp_push && (rsp_cnt != CW'(DEPTH));
  assign rsp_pop_ok  = req_rx_rd && !empty_q;
  assign rsp_cnt_nxt = rsp_cnt + CW'(rsp_push_ok) - CW'(rsp_pop_ok);

  byte_fifo #(.DEPTH(DEPTH)) u_cmd_q (
    .clk(clk), .rst(rst), .clr(flush),
    .push(cmd_push_ok), .din(req_tx_data),
    .pop(cmd_pop_ok), .head(cmd_data), .count(cmd_cnt)
  );

  byte_fifo #(.DEPTH(DEPTH)) u_rsp_q (
    .clk(clk), .rst(rst), .clr(1'b0),
    .push(rsp_push_ok), .din(rsp_data),
    .pop(rsp_pop_ok), .head(req_rx_data), .count(rsp_cnt)
  );

  // flags registered from the next-state count; counts only grow on the
  // requester side for full and only shrink on it for empty
  always_ff @(posedge clk) begin
    if (rst) begin
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      full_q  <= (cmd_cnt_nxt == CW'(DEPTH));
      empty_q <= (rsp_cnt_nxt == '0);
    end
  end

  assign req_tx_full  = full_q;
  assign req_rx_empty = empty_q;
  assign cmd_valid    = (cmd_cnt != '0);
  assign rsp_space    = (rsp_cnt != CW'(DEPTH));

  // R3
  full_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(req_tx_full) |-> $past(req_tx_wr));
  // R7
  empty_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(req_rx_empty) |-> $past(req_rx_rd));
  // R4
  full_fall_chk: assert property (@(posedge clk) disable iff (rst)
    req_tx_full && cmd_pop |=> !req_tx_full);
  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
    req_rx_rd && req_rx_empty |=> link_reset && !cmd_valid && !req_tx_full);
  // R6
  empty_fall_chk: assert property (@(posedge clk) disable iff (rst)
    req_rx_empty && rsp_push |=> !req_rx_empty);
  // R2
  full_valid_chk: assert property (@(posedge clk) disable iff (rst)
    req_tx_full |-> cmd_valid);
  // R9
  space_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_space && !req_rx_rd |=> !rsp_space);
endmodule

// File: tb/tb_fetch_link_buffers.sv
`timescale 1ns/1ps
module tb_fetch_link_buffers;
  localparam int D = 8;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] req_tx_data, req_rx_data, cmd_data, rsp_data;
  logic       req_tx_wr, req_tx_full, req_rx_rd, req_rx_empty;
  logic       cmd_pop, cmd_valid, rsp_push, rsp_space, link_reset;

  always #2 clk = ~clk;

  fetch_link_buffers #(.DEPTH(D)) dut (
    .clk(clk), .rst(rst),
    .req_tx_data(req_tx_data), .req_tx_wr(req_tx_wr), .req_tx_full(req_tx_full),
    .req_rx_data(req_rx_data), .req_rx_rd(req_rx_rd), .req_rx_empty(req_rx_empty),
    .cmd_pop(cmd_pop), .cmd_data(cmd_data), .cmd_valid(cmd_valid),
    .rsp_push(rsp_push), .rsp_data(rsp_data), .rsp_space(rsp_space),
    .link_reset(link_reset)
  );

  int checks = 0;
  int fails  = 0;

  logic [7:0] cmd_q[$];
  logic [7:0] rsp_q[$];
  logic       exp_full, exp_empty, exp_lrst;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R3/R4 req_tx_full", req_tx_full, exp_full);
    chk("R6/R7 req_rx_empty", req_rx_empty, exp_empty);
    chk("R8 link_reset", link_reset, exp_lrst);
    chk("R2 cmd_valid", cmd_valid, cmd_q.size() > 0);
    if (cmd_q.size() > 0) chk("R2 cmd_data", cmd_data, cmd_q[0]);
    if (!exp_empty) chk("R6 req_rx_data", req_rx_data, rsp_q[0]);
    chk("R9 rsp_space", rsp_space, rsp_q.size() < D);
  endtask

  task automatic model_edge();
    bit flush;
    int cpre, rpre;
    flush = req_rx_rd && exp_empty;
    if (rst) begin
      cmd_q.delete(); rsp_q.delete();
      exp_full = 0; exp_empty = 1; exp_lrst = 0;
      return;
    end
    cpre = cmd_q.size();
    if (flush) cmd_q.delete();
    else begin
      if (cmd_pop && cpre > 0) void'(cmd_q.pop_front());
      if (req_tx_wr && cpre < D) cmd_q.push_back(req_tx_data);
    end
    rpre = rsp_q.size();
    if (req_rx_rd && !exp_empty) void'(rsp_q.pop_front());
    if (rsp_push && rpre < D) rsp_q.push_back(rsp_data);
    exp_full  = (cmd_q.size() == D);
    exp_empty = (rsp_q.size() == 0);
    exp_lrst  = flush;
  endtask

  task automatic step(input bit r, input bit wr, input logic [7:0] wd, input bit rd,
                      input bit pop, input bit push, input logic [7:0] pd);
    rst = r; req_tx_wr = wr; req_tx_data = wd; req_rx_rd = rd;
    cmd_pop = pop; rsp_push = push; rsp_data = pd;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    exp_full = 0; exp_empty = 1; exp_lrst = 0;
    rst = 1; req_tx_wr = 0; req_tx_data = 0; req_rx_rd = 0;
    cmd_pop = 0; rsp_push = 0; rsp_data = 0;
    @(negedge clk);
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    // R1 reset values at the ports
    chk("R1 full after reset", req_tx_full, 0);
    chk("R1 empty after reset", req_rx_empty, 1);
    chk("R1 link_reset after reset", link_reset, 0);
    chk("R1 cmd_valid after reset", cmd_valid, 0);

    // R10 capacity: exactly D writes fill it; R3 full follows the last write
    for (int i = 0; i < D; i++) begin
      chk("R3 not full before last write", req_tx_full, 0);
      step(0, 1, 8'h10 + 8'(i), 0, 0, 0, 0);
    end
    chk("R10/R3 full after DEPTH writes", req_tx_full, 1);
    // R5 write while full dropped
    step(0, 1, 8'hEE, 0, 0, 0, 0);
    chk("R5 head unchanged after dropped write", cmd_data, 8'h10);
    // R5 write+pop while full
    step(0, 1, 8'hEF, 0, 1, 0, 0);
    chk("R4 full low after pop", req_tx_full, 0);
    chk("R5 head after pop", cmd_data, 8'h11);
    // R4 idle and pops never raise full
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, i[0], 0, 0);
    chk("R4 full stays low without writes", req_tx_full, 0);

    // R6 responses
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 1, 8'hA0 + 8'(i));
    chk("R6 empty low after push", req_rx_empty, 0);
    chk("R6 first response byte", req_rx_data, 8'hA0);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, 0, 0);
    chk("R7 empty after draining read", req_rx_empty, 1);

    // R8 reset request with pending command and concurrent write
    step(0, 1, 8'h55, 1, 1, 0, 0);
    chk("R8 link_reset pulse", link_reset, 1);
    chk("R8 command queue cleared", cmd_valid, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R8 pulse one cycle", link_reset, 0);

    // R9 response queue full
    for (int i = 0; i < D + 2; i++) step(0, 0, 0, 0, 0, 1, 8'hC0 + 8'(i));
    chk("R9 no space when full", rsp_space, 0);
    for (int i = 0; i < D; i++) step(0, 0, 0, 1, 0, 0, 0);
    chk("R9/R7 drained to empty", req_rx_empty, 1);

    // mixed random traffic
    for (int i = 0; i < 3000; i++)
      step(0, ($urandom % 3) != 0, 8'($urandom), ($urandom % 3) == 0,
           ($urandom % 4) == 0, ($urandom % 2) == 0, 8'($urandom));

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule